// File: doc/BRIEF.md
# Extended-Precision NaN Select Unit

This unit sits beside the execution path of a floating-point unit that works on 80-bit extended-precision values. It receives a source and a destination operand. Each operand holds a sign bit in bit 79, a 15-bit biased exponent in bits 78:64 and a 64-bit significand in bits 63:0. The significand carries an explicit integer bit in bit 63 and a quiet bit in bit 62. The unit classifies both operands. When at least one operand is a NaN, it produces the NaN that the two-operand operation must return.

A signaling NaN on either input raises an exception flag. If the matching enable is set, the unit raises a trap and withholds the write to the destination. If the enable is clear, the unit quiets each signaling NaN and then applies the ordinary quiet-NaN choice. When neither operand is a NaN, the unit only reports that the arithmetic path should proceed and write its own result. The unit also presents the default NaN and default infinity encodings as constants.

With the default parameter `REG_OUT = 1`, every result is registered and appears one clock after the input strobe. With `REG_OUT = 0`, the outputs follow the inputs combinationally.

Top module: `xnan_select`

## Requirements
- R1: An operand with exponent 0 is class 0 (zero) when all 64 significand bits are 0, and class 1 (denormal) otherwise. A denormal with bit 63 set is still class 1 and raises no flag.
- R2: An operand with exponent between 0x0001 and 0x7FFE is class 2 (normal) when bit 63 is 1, and class 3 (unnormal) when bit 63 is 0. Neither class raises a flag or a trap.
- R3: An operand with exponent 0x7FFF is class 4 (infinity) when bits 62:0 are all 0. Otherwise it is class 5 (quiet NaN) if bit 62 is 1, and class 6 (signaling NaN) if bit 62 is 0. Bit 63 plays no part in this decision.
- R4: When exactly one operand is a NaN, nan_valid is 1 and result equals that operand, with bit 62 forced to 1.
- R5: When both operands are NaNs, result equals the destination operand, with bit 62 forced to 1.
- R6: snan_flag is 1 for a strobed operation whenever either operand is class 6.
- R7: When snan_en is 1 and either operand is class 6, trap is 1 and dest_we is 0.
- R8: When snan_en is 0, a signaling NaN does not trap. The unit quiets it by setting bit 62, applies the R4/R5 choice to it, and keeps dest_we at 1.
- R9: When neither operand is a NaN, nan_valid is 0, dest_we is 1, and snan_flag and trap are 0, whatever the value of snan_en.
- R10: dflt_nan is sign 0, exponent 0x7FFF and all 64 significand bits 1. dflt_inf is sign 0, exponent 0x7FFF and all 64 significand bits 0.
- R11: With REG_OUT = 1, all outputs reflect the operands of the cycle in which in_valid is 1, one clock later. out_valid is 1 for exactly that one cycle. snan_flag and trap are 0 whenever out_valid is 0.
- R12: While rst_n is low, out_valid, snan_flag and trap are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src_op | input | 80 | Source operand |
| dst_op | input | 80 | Destination operand |
| snan_en | input | 1 | Signaling-NaN trap enable |
| out_valid | output | 1 | Result strobe |
| src_class | output | 3 | Source class code |
| dst_class | output | 3 | Destination class code |
| nan_valid | output | 1 | Result is a propagated NaN |
| result | output | 80 | Selected quiet NaN |
| snan_flag | output | 1 | Signaling-NaN exception status |
| trap | output | 1 | Enabled signaling-NaN trap |
| dest_we | output | 1 | Destination write permitted |
| dflt_nan | output | 80 | Default NaN encoding |
| dflt_inf | output | 80 | Default infinity encoding |

## Verification
The bench drives pseudo-infinities and pseudo-NaNs whose bit 63 is clear. A unit that tests the integer bit would misclassify them as unnormals. It drives pseudo-denormals with bit 63 set, which a naive decoder would call normal. It also drives a signaling NaN whose only nonzero fraction bit is bit 0, which a quiet-bit-only test would take for an infinity. Pairs of NaNs come in every quiet/signaling combination with snan_en both set and clear. A unit that prefers the source would return the wrong payload. A unit that forgets to quiet would leave bit 62 clear. A unit that ignores the enable would still assert dest_we during a trap.

// File: rtl/xnan_pkg.sv
package xnan_pkg;
  localparam int unsigned XP_EXP_W = 15;
  localparam int unsigned XP_SIG_W = 64;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORM   = 3'd2,
    CLS_UNNORM = 3'd3,
    CLS_INF    = 3'd4,
    CLS_QNAN   = 3'd5,
    CLS_SNAN   = 3'd6
  } xcls_e;
endpackage

// File: rtl/xnan_classify.sv
module xnan_classify
  import xnan_pkg::*;
#(
  parameter int unsigned EXP_W = XP_EXP_W,
  parameter int unsigned SIG_W = XP_SIG_W
) (
  input  logic [EXP_W+SIG_W:0] op_i,
  output xcls_e                cls_o
);
  logic [EXP_W-1:0] expo;
  logic [SIG_W-1:0] sig;
  logic [SIG_W-2:0] frac;

  assign expo = op_i[SIG_W +: EXP_W];
  assign sig  = op_i[SIG_W-1:0];
  assign frac = sig[SIG_W-2:0];

  // integer bit is consulted only for finite nonzero exponents
  always_comb begin
    cls_o = CLS_NORM;
    if (expo == '0) begin
      if (sig == '0) cls_o = CLS_ZERO;
      else           cls_o = CLS_DENORM;
    end else if (&expo) begin
      if (frac == '0)         cls_o = CLS_INF;
      else if (sig[SIG_W-2])  cls_o = CLS_QNAN;
      else                    cls_o = CLS_SNAN;
    end else begin
      if (sig[SIG_W-1]) cls_o = CLS_NORM;
      else              cls_o = CLS_UNNORM;
    end
  end
endmodule

// File: rtl/xnan_pick.sv
module xnan_pick
  import xnan_pkg::*;
#(
  parameter int unsigned EXP_W = XP_EXP_W,
  parameter int unsigned SIG_W = XP_SIG_W
) (
  input  logic [EXP_W+SIG_W:0] src_i,
  input  logic [EXP_W+SIG_W:0] dst_i,
  input  xcls_e                src_cls_i,
  input  xcls_e                dst_cls_i,
  input  logic                 snan_en_i,
  output logic                 nan_o,
  output logic [EXP_W+SIG_W:0] res_o,
  output logic                 snan_o,
  output logic                 trap_o,
  output logic                 we_o
);
  localparam int unsigned OP_W = EXP_W + SIG_W + 1;
  localparam logic [OP_W-1:0] QMASK = {{(OP_W-1){1'b0}}, 1'b1} << (SIG_W-2);

  logic src_nan, dst_nan;
  logic [OP_W-1:0] src_q, dst_q;

  assign src_nan = (src_cls_i == CLS_QNAN) || (src_cls_i == CLS_SNAN);
  assign dst_nan = (dst_cls_i == CLS_QNAN) || (dst_cls_i == CLS_SNAN);
  assign src_q   = src_i | QMASK;
  assign dst_q   = dst_i | QMASK;

  always_comb begin
    snan_o = (src_cls_i == CLS_SNAN) || (dst_cls_i == CLS_SNAN);
    trap_o = snan_o && snan_en_i;
    we_o   = !trap_o;
    nan_o  = src_nan || dst_nan;
    if (dst_nan)      res_o = dst_q;
    else if (src_nan) res_o = src_q;
    else              res_o = '0;
  end
endmodule

// File: rtl/xnan_select.sv
module xnan_select
  import xnan_pkg::*;
#(
  parameter int unsigned EXP_W   = XP_EXP_W,
  parameter int unsigned SIG_W   = XP_SIG_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+SIG_W:0] src_op,
  input  logic [EXP_W+SIG_W:0] dst_op,
  input  logic                 snan_en,
  output logic                 out_valid,
  output logic [2:0]           src_class,
  output logic [2:0]           dst_class,
  output logic                 nan_valid,
  output logic [EXP_W+SIG_W:0] result,
  output logic                 snan_flag,
  output logic                 trap,
  output logic                 dest_we,
  output logic [EXP_W+SIG_W:0] dflt_nan,
  output logic [EXP_W+SIG_W:0] dflt_inf
);
  localparam int unsigned OP_W  = EXP_W + SIG_W + 1;
  localparam int unsigned N_OPS = 2;

  logic [OP_W-1:0] op_a  [N_OPS];
  xcls_e           cls_a [N_OPS];

  assign op_a[0] = src_op;
  assign op_a[1] = dst_op;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    xnan_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .op_i  (op_a[g]),
      .cls_o (cls_a[g])
    );
  end

  logic            c_nan, c_snan, c_trap, c_we;
  logic [OP_W-1:0] c_res;

  xnan_pick #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_pick (
    .src_i     (src_op),
    .dst_i     (dst_op),
    .src_cls_i (cls_a[0]),
    .dst_cls_i (cls_a[1]),
    .snan_en_i (snan_en),
    .nan_o     (c_nan),
    .res_o     (c_res),
    .snan_o    (c_snan),
    .trap_o    (c_trap),
    .we_o      (c_we)
  );

  // status next state: qualified by the input strobe
  logic v_d, f_d, t_d;
  always_comb begin
    v_d = in_valid;
    f_d = in_valid && c_snan;
    t_d = in_valid && c_trap;
  end

  if (REG_OUT) begin : g_reg
    logic            v_q, f_q, t_q;
    logic [2:0]      sc_q, dc_q;
    logic            nv_q, we_q;
    logic [OP_W-1:0] r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        f_q <= 1'b0;
        t_q <= 1'b0;
      end else begin
        v_q <= v_d;
        f_q <= f_d;
        t_q <= t_d;
      end
    end

    always_ff @(posedge clk) begin
      if (in_valid) begin
        sc_q <= cls_a[0];
        dc_q <= cls_a[1];
        nv_q <= c_nan;
        we_q <= c_we;
        r_q  <= c_res;
      end
    end

    assign out_valid = v_q;
    assign snan_flag = f_q;
    assign trap      = t_q;
    assign src_class = sc_q;
    assign dst_class = dc_q;
    assign nan_valid = nv_q;
    assign dest_we   = we_q;
    assign result    = r_q;
  end else begin : g_comb
    assign out_valid = v_d;
    assign snan_flag = f_d;
    assign trap      = t_d;
    assign src_class = cls_a[0];
    assign dst_class = cls_a[1];
    assign nan_valid = c_nan;
    assign dest_we   = c_we;
    assign result    = c_res;
  end

  assign dflt_nan = {1'b0, {EXP_W{1'b1}}, {SIG_W{1'b1}}};
  assign dflt_inf = {1'b0, {EXP_W{1'b1}}, {SIG_W{1'b0}}};
endmodule

// File: rtl/xnan_select_chk.sv
module xnan_select_chk #(
  parameter int unsigned EXP_W   = 15,
  parameter int unsigned SIG_W   = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 nan_valid,
  input logic [EXP_W+SIG_W:0] result,
  input logic                 snan_flag,
  input logic                 trap,
  input logic                 dest_we
);
  // R7
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !dest_we);

  // R7
  trap_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> snan_flag);

  // R11
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!snan_flag && !trap));

  // R8
  quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nan_valid) |-> ((&result[SIG_W +: EXP_W]) && result[SIG_W-2]));

  // R9
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !nan_valid) |-> (dest_we && !snan_flag));

  if (REG_OUT) begin : g_lat
    // R11
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
  end
endmodule

bind xnan_select xnan_select_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .nan_valid (nan_valid),
  .result    (result),
  .snan_flag (snan_flag),
  .trap      (trap),
  .dest_we   (dest_we)
);

// File: tb/sim_xnan_select.sv
module sim_xnan_select;
  logic        clk, rst_n, in_valid, snan_en;
  logic [79:0] src_op, dst_op;
  logic        out_valid, nan_valid, snan_flag, trap, dest_we;
  logic [2:0]  src_class, dst_class;
  logic [79:0] result, dflt_nan, dflt_inf;

  int n_chk = 0;
  int n_bad = 0;

  xnan_select u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_op(src_op), .dst_op(dst_op),
    .snan_en(snan_en), .out_valid(out_valid), .src_class(src_class), .dst_class(dst_class),
    .nan_valid(nan_valid), .result(result), .snan_flag(snan_flag), .trap(trap),
    .dest_we(dest_we), .dflt_nan(dflt_nan), .dflt_inf(dflt_inf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // class code from the requirement text (R1, R2, R3)
  function automatic logic [2:0] m_cls(input logic [79:0] x);
    logic [14:0] e;
    e = x[78:64];
    if (e == 15'd0) return (x[63:0] == 64'd0) ? 3'd0 : 3'd1;
    if (e == 15'h7fff) begin
      if (x[62:0] == 63'd0) return 3'd4;
      return x[62] ? 3'd5 : 3'd6;
    end
    return x[63] ? 3'd2 : 3'd3;
  endfunction

  function automatic string cls_tag(input logic [2:0] c);
    if (c <= 3'd1) return "R1 class";
    if (c <= 3'd3) return "R2 class";
    return "R3 class";
  endfunction

  task automatic apply(input logic [79:0] s, input logic [79:0] d, input logic en);
    logic [2:0]  sc, dc;
    logic        sn, ns, nd, tr;
    logic [79:0] er;
    sc = m_cls(s);
    dc = m_cls(d);
    ns = (sc == 3'd5) || (sc == 3'd6);
    nd = (dc == 3'd5) || (dc == 3'd6);
    sn = (sc == 3'd6) || (dc == 3'd6);
    tr = sn && en;
    er = nd ? (d | (80'd1 << 62)) : (ns ? (s | (80'd1 << 62)) : 80'd0);
    @(negedge clk);
    src_op = s; dst_op = d; snan_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 out_valid", {79'd0, out_valid}, 80'd1);
    check(cls_tag(sc), {77'd0, src_class}, {77'd0, sc});
    check(cls_tag(dc), {77'd0, dst_class}, {77'd0, dc});
    check("R4 nan_valid", {79'd0, nan_valid}, {79'd0, ns || nd});
    if (ns || nd) begin
      if (sn && !en) check("R8 quieted result", result, er);
      else if (ns && nd) check("R5 dest wins", result, er);
      else check("R4 single NaN", result, er);
    end
    check("R6 snan_flag", {79'd0, snan_flag}, {79'd0, sn});
    check("R7 trap", {79'd0, trap}, {79'd0, tr});
    if (ns || nd) check("R7 dest_we", {79'd0, dest_we}, {79'd0, !tr});
    else check("R9 dest_we", {79'd0, dest_we}, 80'd1);
    @(negedge clk);
    check("R11 strobe ends", {78'd0, out_valid, snan_flag | trap}, 80'd0);
  endtask

  function automatic logic [79:0] mk(input int kind);
    logic        sg;
    logic [14:0] e;
    logic [63:0] r;
    sg = 1'($urandom);
    r  = {$urandom, $urandom};
    e  = 15'(1 + ($urandom % 32766));
    case (kind)
      0: return {sg, 15'd0, 64'd0};
      1: return {sg, 15'd0, r | 64'd1};
      2: return {sg, e, 1'b1, r[62:0]};
      3: return {sg, e, 1'b0, r[62:0]};
      4: return {sg, 15'h7fff, r[63], 63'd0};
      5: return {sg, 15'h7fff, r[63], 1'b1, r[61:0]};
      6: return {sg, 15'h7fff, r[63], 1'b0, r[61:0] | 62'd1};
      default: return {sg, 15'($urandom), r};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; snan_en = 1'b0; src_op = '0; dst_op = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {77'd0, out_valid, snan_flag, trap}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 constant encodings
    check("R10 dflt_nan", dflt_nan, {1'b0, 15'h7fff, 64'hffff_ffff_ffff_ffff});
    check("R10 dflt_inf", dflt_inf, {1'b0, 15'h7fff, 64'd0});
    // R1 pseudo-denormal and zero
    apply({1'b0, 15'd0, 64'h8000_0000_0000_0001}, {1'b1, 15'd0, 64'd0}, 1'b1);
    // R2 unnormal against normal, enable set, no NaN (R9)
    apply({1'b0, 15'h3fff, 64'h0000_0000_0000_0001}, {1'b0, 15'h7ffe, 64'h8000_0000_0000_0000}, 1'b1);
    // R3 pseudo-infinity and pseudo-NaN with integer bit clear
    apply({1'b1, 15'h7fff, 64'd0}, {1'b0, 15'h7fff, 64'h4000_0000_0000_0000}, 1'b0);
    // R3 signaling NaN with only bit 0 in the fraction, no enable (R8)
    apply({1'b0, 15'h7fff, 64'h0000_0000_0000_0001}, {1'b0, 15'h1234, 64'h8000_0000_0000_0000}, 1'b0);
    // R5 two quiet NaNs
    apply({1'b0, 15'h7fff, 64'hc000_0000_0000_00aa}, {1'b1, 15'h7fff, 64'h4000_0000_0000_0055}, 1'b1);
    // R7 signaling source with enable
    apply({1'b0, 15'h7fff, 64'h8000_0000_0000_0777}, {1'b0, 15'h4000, 64'h8000_0000_0000_0000}, 1'b1);
    // R8 two signaling NaNs, no enable: quieted destination
    apply({1'b0, 15'h7fff, 64'h0000_0000_0000_0123}, {1'b1, 15'h7fff, 64'h8000_0000_0000_0456}, 1'b0);
    // R7 signaling destination with enable
    apply({1'b0, 15'h7fff, 64'hc000_0000_0000_0001}, {1'b0, 15'h7fff, 64'h0000_0001_0000_0000}, 1'b1);
    for (int i = 0; i < 400; i++) begin
      apply(mk(int'($urandom % 8)), mk(int'($urandom % 8)), 1'($urandom));
    end
    // R12 reset during idle
    rst_n = 1'b0;
    #1;
    check("R12 async reset", {77'd0, out_valid, snan_flag, trap}, 80'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule